// File: doc/BRIEF.md
# DMA Channel Transfer-Count Register Bank

This block holds the per-channel count and peripheral-address state for a seven-channel DMA engine. It sits on a simple memory-mapped bus. Each channel has two registers. The first is an 18-bit transfer counter that software loads while the channel is idle. The second is a 32-bit peripheral address that software can rewrite at any time. Reads are combinational, so the read data for the presented address appears in the same cycle. A write is taken on the clock edge while the write strobe is high.

Each channel gets its enable and circular-mode bits from a control register that lives elsewhere. Each time the engine finishes a read-then-write move for that channel, it pulses a per-channel done line. The counter then steps down by one. When a move brings the counter from one to zero, one of two things happens:

- With circular mode off, the counter stays at zero.
- With circular mode on, the counter takes back the value software last loaded.

A zero count tells the engine not to serve the channel, whatever the enable state. A one-cycle completion pulse flags the end of each block of moves.

Top module: `dma_cnt_regbank`

## Requirements
- R1: After reset, every register reads 0x0000_0000, `ch_ready` is all zero and `ch_tc` is all zero.
- R2: For channel x (1 to 7), the counter is at byte offset 0x0C + 0x14*(x-1) and the peripheral address is at 0x10 + 0x14*(x-1). Channel x uses bit x-1 of every per-channel vector. A write is taken on the clock edge with `bus_wr` high. `bus_rdata` shows the addressed register in the same cycle.
- R3: The counter is held in data bits 17:0. On a counter read, bits 31:18 read as zero. Writes to bits 31:18 have no effect.
- R4: The peripheral address is a 32-bit register that can be read and written whether or not the channel is enabled.
- R5: When the channel is enabled and its done bit is high at a clock edge, a non-zero count decreases by one. The new value is readable after that edge.
- R6: A done pulse has no effect on the count while the channel is disabled.
- R7: With circular mode off, a count that has reached zero stays at zero under further done pulses.
- R8: With circular mode on, a done pulse at a count of one loads the counter with the last value software wrote to it.
- R9: `ch_ready[x-1]` is high exactly when the channel's count is non-zero, regardless of its enable bit.
- R10: While the channel is enabled, writes to its counter are ignored. This covers both the visible count and the value used for circular reload.
- R11: `ch_tc[x-1]` is high for the single cycle after a done pulse that takes the count from one to zero. This holds in both modes, and the pulse repeats on every such transfer.
- R12: Unmapped offsets read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Byte offset of the register being accessed |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ch_en | input | 7 | Per-channel enable from the control register |
| ch_circ | input | 7 | Per-channel circular-mode bit |
| xfer_done | input | 7 | Per-channel pulse, one per completed read-then-write move |
| ch_ready | output | 7 | Channel may be served (count non-zero) |
| ch_tc | output | 7 | One-cycle block-complete pulse |

## Verification
A corrupted counter shows up as the wrong value on `bus_rdata` at the next read. It also shows up at once on `ch_ready`, because that output follows the count without any pipelining. A wrong reload value stays hidden until a circular channel wraps. The completion pulse and the reloaded count then expose it in the cycle after the last move, so the bench runs full blocks through wrap-around. A decode fault moves or mirrors a register, and only a sweep of every offset after distinct writes to every register can catch it.

// File: rtl/dma_cnt_pkg.sv
package dma_cnt_pkg;

  // Action selected for a channel counter in one cycle.
  typedef enum logic [1:0] {
    CNT_HOLD,
    CNT_LOAD_SW,
    CNT_DEC,
    CNT_WRAP
  } cnt_act_e;

endpackage

// File: rtl/dma_addr_dec.sv
module dma_addr_dec #(
  parameter int unsigned NUM_CH     = 7,
  parameter int unsigned AW         = 8,
  parameter int unsigned CNT_BASE   = 32'h0C,
  parameter int unsigned PADDR_BASE = 32'h10,
  parameter int unsigned STRIDE     = 32'h14
) (
  input  logic [AW-1:0]     addr,
  output logic [NUM_CH-1:0] cnt_hit,
  output logic [NUM_CH-1:0] paddr_hit
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [AW-1:0] CNT_OFS   = AW'(CNT_BASE + STRIDE * g);
    localparam logic [AW-1:0] PADDR_OFS = AW'(PADDR_BASE + STRIDE * g);
    assign cnt_hit[g]   = (addr == CNT_OFS);
    assign paddr_hit[g] = (addr == PADDR_OFS);
  end

endmodule

// File: rtl/dma_ch_counter.sv
module dma_ch_counter
  import dma_cnt_pkg::*;
#(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             circ,
  input  logic             done,
  input  logic             sw_wr,
  input  logic [CNT_W-1:0] sw_data,
  output logic [CNT_W-1:0] count,
  output logic             ready,
  output logic             tc
);

  cnt_act_e         act;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] shadow_q;
  logic             tc_q, tc_d;
  logic             non_zero;
  logic             last_item;

  assign non_zero  = (cnt_q != '0);
  assign last_item = (cnt_q == CNT_W'(1));

  // Software may load only while the channel is idle; hardware counts only while enabled.
  always_comb begin
    act = CNT_HOLD;
    if (!en) begin
      if (sw_wr) act = CNT_LOAD_SW;
    end else if (done && non_zero) begin
      act = last_item ? CNT_WRAP : CNT_DEC;
    end
  end

  always_comb begin
    case (act)
      CNT_LOAD_SW: cnt_d = sw_data;
      CNT_DEC:     cnt_d = cnt_q - CNT_W'(1);
      CNT_WRAP:    cnt_d = circ ? shadow_q : '0;
      default:     cnt_d = cnt_q;
    endcase
    tc_d = (act == CNT_WRAP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      shadow_q <= '0;
      tc_q     <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tc_q  <= tc_d;
      if (act == CNT_LOAD_SW) shadow_q <= sw_data;
    end
  end

  assign count = cnt_q;
  assign ready = non_zero;
  assign tc    = tc_q;

endmodule

// File: rtl/dma_rd_mux.sv
module dma_rd_mux #(
  parameter int unsigned NUM_CH = 7,
  parameter int unsigned CNT_W  = 18,
  parameter int unsigned DW     = 32
) (
  input  logic [NUM_CH-1:0]            cnt_hit,
  input  logic [NUM_CH-1:0]            paddr_hit,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cnt_val,
  input  logic [NUM_CH-1:0][DW-1:0]    paddr_val,
  output logic [DW-1:0]                rdata
);

  // Hits are one-hot or empty, so an OR tree is an exact mux; an empty hit reads zero.
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (cnt_hit[i])   rdata = rdata | DW'(cnt_val[i]);
      if (paddr_hit[i]) rdata = rdata | paddr_val[i];
    end
  end

endmodule

// File: rtl/dma_cnt_regbank.sv
module dma_cnt_regbank
  import dma_cnt_pkg::*;
#(
  parameter int unsigned NUM_CH     = 7,
  parameter int unsigned CNT_W      = 18,
  parameter int unsigned DW         = 32,
  parameter int unsigned AW         = 8,
  parameter int unsigned CNT_BASE   = 32'h0C,
  parameter int unsigned PADDR_BASE = 32'h10,
  parameter int unsigned STRIDE     = 32'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] ch_circ,
  input  logic [NUM_CH-1:0] xfer_done,
  output logic [NUM_CH-1:0] ch_ready,
  output logic [NUM_CH-1:0] ch_tc
);

  localparam int unsigned SYNC_STAGES = 2;

  // Reset: asserted asynchronously, released on the clock.
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  logic [NUM_CH-1:0]            cnt_hit, paddr_hit;
  logic [NUM_CH-1:0]            cnt_we, paddr_we;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_val;
  logic [NUM_CH-1:0][DW-1:0]    paddr_q;

  dma_addr_dec #(
    .NUM_CH    (NUM_CH),
    .AW        (AW),
    .CNT_BASE  (CNT_BASE),
    .PADDR_BASE(PADDR_BASE),
    .STRIDE    (STRIDE)
  ) u_dec (
    .addr     (bus_addr),
    .cnt_hit  (cnt_hit),
    .paddr_hit(paddr_hit)
  );

  assign cnt_we   = bus_wr ? cnt_hit   : '0;
  assign paddr_we = bus_wr ? paddr_hit : '0;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dma_ch_counter #(
      .CNT_W(CNT_W)
    ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .en     (ch_en[g]),
      .circ   (ch_circ[g]),
      .done   (xfer_done[g]),
      .sw_wr  (cnt_we[g]),
      .sw_data(bus_wdata[CNT_W-1:0]),
      .count  (cnt_val[g]),
      .ready  (ch_ready[g]),
      .tc     (ch_tc[g])
    );

    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n)       paddr_q[g] <= '0;
      else if (paddr_we[g]) paddr_q[g] <= bus_wdata;
    end
  end

  dma_rd_mux #(
    .NUM_CH(NUM_CH),
    .CNT_W (CNT_W),
    .DW    (DW)
  ) u_rd (
    .cnt_hit  (cnt_hit),
    .paddr_hit(paddr_hit),
    .cnt_val  (cnt_val),
    .paddr_val(paddr_q),
    .rdata    (bus_rdata)
  );

endmodule

// File: rtl/dma_cnt_regbank_chk.sv
module dma_cnt_regbank_chk #(
  parameter int unsigned NUM_CH   = 7,
  parameter int unsigned CNT_W    = 18,
  parameter int unsigned DW       = 32,
  parameter int unsigned AW       = 8,
  parameter int unsigned CNT_BASE = 32'h0C,
  parameter int unsigned STRIDE   = 32'h14
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     bus_addr,
  input logic              bus_wr,
  input logic [DW-1:0]     bus_rdata,
  input logic [NUM_CH-1:0] ch_en,
  input logic [NUM_CH-1:0] ch_circ,
  input logic [NUM_CH-1:0] xfer_done,
  input logic [NUM_CH-1:0] ch_ready,
  input logic [NUM_CH-1:0] ch_tc
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [AW-1:0] CNT_OFS = AW'(CNT_BASE + STRIDE * g);

    // R3
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == CNT_OFS) |-> (bus_rdata[DW-1:CNT_W] == '0));

    // R11
    tc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_tc[g] |-> $past(ch_en[g] && xfer_done[g]));

    // R7
    nocirc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_tc[g] && !$past(ch_circ[g])) |-> !ch_ready[g]);

    // R8
    circ_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_tc[g] && $past(ch_circ[g])) |-> ch_ready[g]);

    // R9
    ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ch_ready[g]) && !$past(bus_wr)) |-> ch_tc[g]);

    // R6
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(ch_en[g]) && !$past(bus_wr)) |-> $stable(ch_ready[g]));

    // R10
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ch_en[g] && !xfer_done[g]) |-> $stable(ch_ready[g]));
  end

endmodule

bind dma_cnt_regbank dma_cnt_regbank_chk #(
  .NUM_CH  (NUM_CH),
  .CNT_W   (CNT_W),
  .DW      (DW),
  .AW      (AW),
  .CNT_BASE(CNT_BASE),
  .STRIDE  (STRIDE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_rdata(bus_rdata),
  .ch_en    (ch_en),
  .ch_circ  (ch_circ),
  .xfer_done(xfer_done),
  .ch_ready (ch_ready),
  .ch_tc    (ch_tc)
);

// File: tb/tb_dma_cnt_regbank.sv
`timescale 1ns/1ps
module tb_dma_cnt_regbank;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [6:0]  ch_en, ch_circ, xfer_done, ch_ready, ch_tc;

  int vectors = 0;
  int miscompares = 0;
  bit done_flag = 0;

  // Bench-side model of the registers.
  logic [17:0] cnt_m [7];
  logic [17:0] sh_m  [7];
  logic [31:0] adr_m [7];
  logic [6:0]  tc_m;

  dma_cnt_regbank dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_en(ch_en),
    .ch_circ(ch_circ), .xfer_done(xfer_done), .ch_ready(ch_ready), .ch_tc(ch_tc)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int cnt_ch(input logic [7:0] a);
    for (int k = 0; k < 7; k++) if (a == 8'(12 + 20 * k)) return k;
    return -1;
  endfunction

  function automatic int adr_ch(input logic [7:0] a);
    for (int k = 0; k < 7; k++) if (a == 8'(16 + 20 * k)) return k;
    return -1;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    if (cnt_ch(a) >= 0) return {14'd0, cnt_m[cnt_ch(a)]};
    if (adr_ch(a) >= 0) return adr_m[adr_ch(a)];
    return 32'd0;
  endfunction

  function automatic logic [6:0] exp_ready();
    logic [6:0] r;
    for (int k = 0; k < 7; k++) r[k] = (cnt_m[k] != 18'd0);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (cnt_ch(a) >= 0 && !ch_en[cnt_ch(a)]) begin
      cnt_m[cnt_ch(a)] = d[17:0];
      sh_m[cnt_ch(a)]  = d[17:0];
    end
    if (adr_ch(a) >= 0) adr_m[adr_ch(a)] = d;
  endtask

  task automatic read_chk(input string tag, input logic [7:0] a);
    @(negedge clk);
    bus_addr = a;
    #2;
    chk(tag, bus_rdata, exp_rd(a));
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < 256; a++) read_chk(tag, 8'(a));
  endtask

  // Pulse done on the channels in mask, then check counts, ready and tc after the edge.
  task automatic pulse(input string tag, input logic [6:0] mask);
    @(negedge clk);
    xfer_done = mask;
    @(negedge clk);
    xfer_done = '0;
    tc_m = '0;
    for (int k = 0; k < 7; k++) begin
      if (mask[k] && ch_en[k] && cnt_m[k] != 18'd0) begin
        cnt_m[k] = cnt_m[k] - 18'd1;
        if (cnt_m[k] == 18'd0) begin
          tc_m[k] = 1'b1;
          if (ch_circ[k]) cnt_m[k] = sh_m[k];
        end
      end
    end
    chk({tag, " tc R11"}, 32'(ch_tc), 32'(tc_m));
    chk({tag, " ready R9"}, 32'(ch_ready), 32'(exp_ready()));
    for (int k = 0; k < 7; k++) begin
      if (mask[k]) begin
        bus_addr = 8'(12 + 20 * k);
        #1;
        chk({tag, " count"}, bus_rdata, exp_rd(bus_addr));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    ch_en = '0; ch_circ = '0; xfer_done = '0; tc_m = '0;
    for (int k = 0; k < 7; k++) begin cnt_m[k] = '0; sh_m[k] = '0; adr_m[k] = '0; end
    repeat (3) @(negedge clk);
    chk("R1 ready", 32'(ch_ready), 32'd0);
    chk("R1 tc", 32'(ch_tc), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 and R12: everything reads zero after reset
    sweep("R1 reset sweep");

    // R2, R3, R4: distinct values in every register; channel 7 gets only reserved bits set
    for (int k = 0; k < 7; k++) begin
      bus_write(8'(12 + 20 * k), (k == 6) ? 32'hFFFC_0000 : (32'hFFFC_0000 | 32'((k + 1) * 32'h2345)));
      bus_write(8'(16 + 20 * k), 32'hA5C3_0000 ^ 32'((k + 1) * 32'h0101_1111));
    end
    // R12: writes to every unmapped offset
    for (int a = 0; a < 256; a++)
      if (cnt_ch(8'(a)) < 0 && adr_ch(8'(a)) < 0) bus_write(8'(a), 32'hFFFF_FFFF);
    sweep("R2 R3 R12 map sweep");
    @(negedge clk);
    chk("R9 ready after load", 32'(ch_ready), 32'(exp_ready()));

    // R6: done pulses on disabled channels change nothing
    pulse("R6 disabled", 7'h7F);

    // R5, R10, R11, R7 on channel 3 (bit 2), non-circular
    bus_write(8'(12 + 40), 32'd4);
    ch_en[2] = 1'b1;
    bus_write(8'(12 + 40), 32'd100);
    read_chk("R10 locked write", 8'(12 + 40));
    for (int i = 0; i < 4; i++) pulse("R5 decrement", 7'b0000100);
    @(negedge clk);
    chk("R11 single cycle", 32'(ch_tc), 32'd0);
    pulse("R7 stay zero", 7'b0000100);
    pulse("R7 stay zero", 7'b0000100);
    ch_en[2] = 1'b0;

    // R8, R10 on channel 5 (bit 4), circular
    bus_write(8'(12 + 80), 32'd3);
    ch_en[4] = 1'b1; ch_circ[4] = 1'b1;
    bus_write(8'(12 + 80), 32'd50);
    for (int i = 0; i < 5; i++) pulse("R8 circular", 7'b0010000);
    // R4: address writable while enabled
    bus_write(8'(16 + 80), 32'h1357_9BDF);
    read_chk("R4 enabled write", 8'(16 + 80));

    // R11: reload value of one gives a pulse on every move; two channels at once
    bus_write(8'(12 + 100), 32'd1);
    bus_write(8'(12 + 20), 32'd2);
    ch_en[5] = 1'b1; ch_circ[5] = 1'b1; ch_en[1] = 1'b1;
    for (int i = 0; i < 3; i++) pulse("R11 repeat", 7'b0110010);

    // R10: after disabling, the locked write left the reload value intact
    ch_en[4] = 1'b0; ch_en[5] = 1'b0; ch_en[1] = 1'b0;
    sweep("R12 final sweep");

    done_flag = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule